// File: doc/BRIEF.md
# Clause 22 MDIO Management Master

This block runs IEEE 802.3 Clause 22 management frames towards external PHY devices. Software sees a single 32-bit command/status word on a plain write/read port. Writing that word while the block is idle starts one read or write frame on the MDC/MDIO pins. Reading the word returns the last accepted command, a busy flag, a read-valid flag and, once a read has finished, the 16-bit value returned by the PHY.

MDC comes from the system clock through a parameterized divider and sits low between frames. MDIO leaves the block as a data bit plus an output-enable for a tri-state pad. The enable is dropped for the turnaround and data phases of a read, so the PHY can drive the line. Output bits change when MDC falls, and input bits are sampled when MDC rises.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The command/status word reads back with these fields: bits 15:0 data, bits 20:16 PHY address, bits 25:21 register address, bit 26 operation (1 = read, 0 = write), bit 27 read-valid, bit 28 busy, and bits 31:29 always zero.
- R2: A write while busy is 0 is accepted. Busy reads 1 from the next cycle until the last frame bit has been shifted out.
- R3: Every frame is 32 + 32 bits and is sent MSB first, in this order: 32 ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, 2 turnaround bits (`10` on writes), then 16 data bits. A write carries bits 15:0 of the command.
- R4: The output-enable is high for all 64 bits of a write. On a read it is high for bits 0..45 and low for bits 46..63. It is low whenever busy is 0.
- R5: On a read, the 16 bits sampled on the rising MDC edges of bits 48..63 (MSB first) appear in bits 15:0 when busy clears, and read-valid is set at the same time.
- R6: Accepting any command clears read-valid. A write frame never sets it.
- R7: A write to the word while busy is 1 is ignored. The command fields and the frame already on the wire are unchanged.
- R8: One MDC period is 2*HALF_DIV system clocks. MDC is low whenever busy is 0. The MDIO output bit changes only on a falling MDC edge or on command acceptance.
- R9: After reset the word reads 0, and MDC and the output-enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the command word |
| regWrData | input | 32 | Command word being written |
| regRdData | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO bit towards the pad |
| mdioOe | output | 1 | MDIO pad output-enable |
| mdioIn | input | 1 | MDIO bit from the pad |

## Verification
The bench builds the block with HALF_DIV = 3 rather than the default 4. This makes each MDC half-period an odd number of system clocks, so an off-by-one in the divider shows up as a wrong measured MDC period. PREAMBLE_BITS stays at 32, so the frame header the bench captures can be compared bit for bit against the 64-bit layout. The short division keeps each frame near 400 cycles. That leaves room for back-to-back read and write frames, a rejected mid-frame write, and all-ones and all-zeros data patterns.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_LSB  = 0;
  localparam int PHY_LSB   = 16;
  localparam int REG_LSB   = 21;
  localparam int OP_BIT    = 26;
  localparam int VALID_BIT = 27;
  localparam int BUSY_BIT  = 28;

  typedef struct packed {
    logic accept;
    logic shiftOut;
    logic sampleIn;
    logic finish;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV      = 4,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        wrIsRead,
  output mdioStrobe_t strb,
  output logic        mdc,
  output logic        busy,
  output logic        driveEn
);
  localparam int FRAME_BITS = PREAMBLE_BITS + 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = $clog2(HALF_DIV + 1);
  localparam int RELEASE_AT = PREAMBLE_BITS + 14;
  localparam int DATA_AT    = PREAMBLE_BITS + 16;

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcR;
  logic             rdOp;
  logic             tick;
  logic             lastBit;

  assign tick    = busy && (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastBit = (bitIdx == IDX_W'(FRAME_BITS - 1));

  always_comb begin
    strb.accept   = regWrEn && !busy;
    strb.shiftOut = tick && mdcR && !lastBit;
    strb.sampleIn = tick && !mdcR && rdOp && (bitIdx >= IDX_W'(DATA_AT));
    strb.finish   = tick && mdcR && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      rdOp   <= 1'b0;
    end else if (strb.accept) begin
      busy   <= 1'b1;
      mdcR   <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
      rdOp   <= wrIsRead;
    end else if (busy) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) begin
        mdcR <= ~mdcR;
        if (mdcR) begin
          if (lastBit) busy <= 1'b0;
          else         bitIdx <= bitIdx + 1'b1;
        end
      end
    end
  end

  assign mdc     = mdcR;
  assign driveEn = busy && !(rdOp && (bitIdx >= IDX_W'(RELEASE_AT)));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  mdioStrobe_t strb,
  input  logic [31:0] regWrData,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        readValid,
  output logic [26:0] cmdWord
);
  localparam int FRAME_BITS = PREAMBLE_BITS + 32;

  logic [FRAME_BITS-1:0] txShift;
  logic [15:0]           rxShift;
  logic [1:0]            opCode;

  assign opCode = regWrData[OP_BIT] ? 2'b10 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift   <= '0;
      rxShift   <= '0;
      cmdWord   <= '0;
      readValid <= 1'b0;
    end else begin
      if (strb.accept) begin
        txShift   <= {{PREAMBLE_BITS{1'b1}}, 2'b01, opCode,
                      regWrData[PHY_LSB +: 5], regWrData[REG_LSB +: 5],
                      2'b10, regWrData[DATA_LSB +: 16]};
        cmdWord   <= regWrData[26:0];
        readValid <= 1'b0;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.sampleIn) rxShift <= {rxShift[14:0], mdioIn};
      if (strb.finish && cmdWord[OP_BIT]) begin
        readValid     <= 1'b1;
        cmdWord[15:0] <= rxShift;
      end
    end
  end

  assign mdioOut = txShift[FRAME_BITS-1];
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV      = 4,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t strb;
  logic        busy;
  logic        readValid;
  logic [26:0] cmdWord;

  mdio_ctrl #(.HALF_DIV(HALF_DIV), .PREAMBLE_BITS(PREAMBLE_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .wrIsRead(regWrData[OP_BIT]),
    .strb(strb), .mdc(mdc), .busy(busy), .driveEn(mdioOe)
  );

  mdio_dp #(.PREAMBLE_BITS(PREAMBLE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .readValid(readValid), .cmdWord(cmdWord)
  );

  assign regRdData = {3'b000, busy, readValid, cmdWord};
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [31:0] regRdData,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  logic busyF;
  logic validF;
  assign busyF  = regRdData[28];
  assign validF = regRdData[27];

  // R2
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !busyF) |=> busyF);

  // R6
  accept_clears_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !busyF) |=> !validF);

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && busyF) |=> (regRdData[26:16] == $past(regRdData[26:16])));

  // R8
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyF |-> !mdc);

  // R8
  out_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyF && $past(busyF) && !$fell(mdc)) |-> $stable(mdioOut));

  // R4
  oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyF |-> !mdioOe);

  // R1
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[31:29] == 3'b000);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdData(regRdData),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  localparam int HALF_DIV = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioInR = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [63:0] seen;
  logic [63:0] oeAt;
  int          riseCnt = 0;
  logic [15:0] respData = '0;
  realtime     lastRise = 0;
  realtime     period = 0;

  always #2 clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(HALF_DIV), .PREAMBLE_BITS(32)) u_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioInR)
  );

  // PHY model: capture on MDC rise, drive read data on MDC fall
  always @(posedge mdc) begin
    if (riseCnt < 64) begin
      seen[63-riseCnt] = mdioOut;
      oeAt[63-riseCnt] = mdioOe;
    end
    if (riseCnt > 0) period = $realtime - lastRise;
    lastRise = $realtime;
    riseCnt++;
  end

  always @(negedge mdc) begin
    if (riseCnt >= 48 && riseCnt < 64) mdioInR = respData[63-riseCnt];
    else mdioInR = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 act=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic rd, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d);
    return {5'b0, rd, rg, phy, d};
  endfunction

  function automatic logic [63:0] mkFrame(input logic rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = w;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (regRdData[28]) @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 readback", {32'b0, regRdData}, 64'h0);
    check("R9 mdc", {63'b0, mdc}, 64'h0);
    check("R9 oe", {63'b0, mdioOe}, 64'h0);
  endtask

  task automatic testWrite(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    riseCnt = 0;
    issue(mkCmd(1'b0, phy, rg, d));
    check("R2 busy after accept", {63'b0, regRdData[28]}, 64'h1);
    waitIdle();
    check("R3 write frame", seen, mkFrame(1'b0, phy, rg, d));
    check("R4 write oe all bits", oeAt, {64{1'b1}});
    check("R1 write readback", {32'b0, regRdData}, {32'b0, mkCmd(1'b0, phy, rg, d)});
    check("R6 write no valid", {63'b0, regRdData[27]}, 64'h0);
    check("R8 mdc low idle", {63'b0, mdc}, 64'h0);
    check("R8 mdc period", 64'(int'(period)), 64'(2 * HALF_DIV * 4));
    check("R4 oe low idle", {63'b0, mdioOe}, 64'h0);
  endtask

  task automatic testRead(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] resp);
    riseCnt = 0;
    respData = resp;
    issue(mkCmd(1'b1, phy, rg, 16'h0));
    check("R6 valid cleared on accept", {63'b0, regRdData[27]}, 64'h0);
    waitIdle();
    check("R3 read header", {18'b0, seen[63:18]}, {18'b0, mkFrame(1'b1, phy, rg, 16'h0) >> 18});
    check("R4 read oe", oeAt, {{46{1'b1}}, 18'b0});
    check("R5 read data", {48'b0, regRdData[15:0]}, {48'b0, resp});
    check("R5 read valid", {63'b0, regRdData[27]}, 64'h1);
    check("R1 read fields", {53'b0, regRdData[26:16]}, {53'b0, 1'b1, rg, phy});
  endtask

  task automatic testBusyIgnore();
    riseCnt = 0;
    issue(mkCmd(1'b0, 5'h0A, 5'h15, 16'hC3A5));
    repeat (40) @(negedge clk);
    issue(mkCmd(1'b1, 5'h1F, 5'h01, 16'h1234));
    check("R7 fields kept", {32'b0, regRdData[26:0], 5'b0} >> 5, {37'b0, mkCmd(1'b0, 5'h0A, 5'h15, 16'hC3A5)} & 64'h7FF_FFFF);
    waitIdle();
    check("R7 frame intact", seen, mkFrame(1'b0, 5'h0A, 5'h15, 16'hC3A5));
    check("R7 readback intact", {32'b0, regRdData}, {32'b0, mkCmd(1'b0, 5'h0A, 5'h15, 16'hC3A5)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite(5'h01, 5'h04, 16'hA55A);
    testRead(5'h1F, 5'h02, 16'h8001);
    testWrite(5'h00, 5'h1F, 16'hFFFF);
    check("R6 write clears valid", {63'b0, regRdData[27]}, 64'h0);
    testRead(5'h05, 5'h00, 16'h0000);
    testRead(5'h12, 5'h0B, 16'hFFFF);
    testBusyIgnore();
    testWrite(5'h15, 5'h0A, 16'h0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule